// File: doc/BRIEF.md
# Per-Stream Ingress Gate Policer

This block applies time-based admission control to received frames. A parsed header is presented for every frame: destination MAC, VLAN ID, priority code point, length and the ingress port. It is compared in parallel against a table of flow entries. Each entry uses one of two key types. A VLAN-aware key compares the destination MAC, the VLAN ID and the priority code point. A VLAN-unaware key compares the destination MAC only. When several entries match, the lowest index is selected. Each entry has a destination port mask, a length limit and a gate. The gate cycles through an open window and then a closed window, and the cycle starts at a programmed base time.

A frame that matches an entry is forwarded only when three conditions hold: the gate of that entry is open, the frame length is within the entry's limit, and the port mask minus the ingress port still contains at least one port. Every other matched frame is dropped. All three drop causes go into one per-flow drop counter, and a separate counter records accepted frames. A frame that matches no entry is passed on unchanged and flagged as unmatched, so that normal forwarding handles it.

Entries are written through one configuration port. A write with an empty port mask is refused. An accepted write restarts the gate of that flow and clears its counters. The time input comes from a shared time engine and must never decrease.

Top module: `psg_policer`

## Requirements
- R1: An entry written with cfg_vlan_aware_i=1 matches a frame only when the destination MAC, the VLAN ID and the PCP are all equal to its key.
- R2: An entry written with cfg_vlan_aware_i=0 matches on the destination MAC alone, whatever the VLAN ID and PCP are.
- R3: When more than one valid entry matches a frame, dec_flow_o reports the lowest entry index, and only that entry's counters change.
- R4: A frame that matches no entry produces dec_fwd_o=1, dec_unmatched_o=1, dec_drop_o=0 and dec_ports_o=0, and no counter changes.
- R5: A flow's gate is closed before its base time B. For every k>=0 it is open in [B+k*P, B+k*P+O) and closed in [B+k*P+O, B+(k+1)*P), where O is the open time, C is the close time and P=O+C. The gate state steps at most one window edge per clock cycle.
- R6: A matched frame with the gate open, a length within the limit and a non-empty effective mask is forwarded (dec_fwd_o=1). dec_ports_o equals the entry mask with the bit at the ingress port index cleared.
- R7: A matched frame that arrives while the gate is closed is dropped (dec_drop_o=1, dec_ports_o=0), and the drop counter of that flow increments.
- R8: A matched frame whose length is greater than the entry's maximum length is dropped and counted as a drop. A length equal to the limit is accepted.
- R9: A matched frame whose effective mask is empty (the entry mask holds only the ingress port) is dropped and counted as a drop.
- R10: Every forwarded matched frame increments the accepted counter of its flow. Counters are read combinationally through cnt_idx_i.
- R11: Both counters saturate at 2^CNT_W-1 and do not wrap.
- R12: A configuration write with cfg_ports_i=0 is ignored. The entry's key, mask, gate and counters all stay unchanged.
- R13: An accepted configuration write clears both counters of that flow and restarts its gate, closed, until the new base time.
- R14: The decision for a header presented with hdr_valid_i=1 appears on the outputs with dec_valid_o=1 exactly one clock cycle later. dec_valid_o is 0 in every other cycle and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | TIME_W | Current time in ns, never decreasing |
| hdr_valid_i | input | 1 | Header present this cycle |
| hdr_dmac_i | input | 48 | Destination MAC |
| hdr_vid_i | input | 12 | VLAN ID |
| hdr_pcp_i | input | 3 | Priority code point |
| hdr_len_i | input | LEN_W | Frame length in bytes |
| hdr_port_i | input | PORT_W | Ingress port index |
| cfg_we_i | input | 1 | Entry write strobe |
| cfg_idx_i | input | FLOW_W | Entry index to write |
| cfg_vlan_aware_i | input | 1 | 1: key uses MAC+VID+PCP, 0: MAC only |
| cfg_dmac_i | input | 48 | Key destination MAC |
| cfg_vid_i | input | 12 | Key VLAN ID |
| cfg_pcp_i | input | 3 | Key PCP |
| cfg_ports_i | input | PORTS | Destination port mask, must be nonzero |
| cfg_max_len_i | input | LEN_W | Maximum accepted length |
| cfg_base_i | input | TIME_W | Gate base time |
| cfg_open_i | input | TIME_W | Open window length in ns |
| cfg_close_i | input | TIME_W | Closed window length in ns |
| dec_valid_o | output | 1 | Decision valid |
| dec_fwd_o | output | 1 | Frame forwarded |
| dec_drop_o | output | 1 | Frame dropped |
| dec_unmatched_o | output | 1 | No entry matched |
| dec_flow_o | output | FLOW_W | Matching entry index |
| dec_ports_o | output | PORTS | Egress port mask for a matched forward |
| cnt_idx_i | input | FLOW_W | Counter read index |
| cnt_acc_o | output | CNT_W | Accepted count of the selected flow |
| cnt_drop_o | output | CNT_W | Drop count of the selected flow |

## Verification
The bench builds the policer with four entries, four ports, 3-bit counters and a 32-bit time. With four entries it can set up two entries that share one MAC, one with each key type, next to an entry with a single port and one kept free for the counter tests, and it still has a MAC that matches nothing. The 3-bit counters saturate after seven frames, so R11 is reached in a handful of cycles. The time is stepped across the window edges and their ns boundaries, including a jump of several periods that the gate must catch up on one edge per cycle.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int MacW = 48;
  localparam int VidW = 12;
  localparam int PcpW = 3;

  typedef struct packed {
    logic            vlan_aware;
    logic [MacW-1:0] dmac;
    logic [VidW-1:0] vid;
    logic [PcpW-1:0] pcp;
  } flow_key_t;

  typedef enum logic {GATE_SHUT = 1'b0, GATE_OPEN = 1'b1} gate_st_e;
endpackage

// File: rtl/psg_flow_match.sv
module psg_flow_match
  import psg_pkg::*;
#(
  parameter int N_FLOWS = 8,
  parameter int FLOW_W  = 3
) (
  input  logic [N_FLOWS-1:0]            vld_i,
  input  flow_key_t [N_FLOWS-1:0]       key_i,
  input  logic [MacW-1:0]               dmac_i,
  input  logic [VidW-1:0]               vid_i,
  input  logic [PcpW-1:0]               pcp_i,
  output logic                          hit_o,
  output logic [FLOW_W-1:0]             idx_o
);
  logic [N_FLOWS-1:0] hit_vec;

  for (genvar i = 0; i < N_FLOWS; i++) begin : g_cmp
    assign hit_vec[i] = vld_i[i] && (key_i[i].dmac == dmac_i) &&
                        (!key_i[i].vlan_aware ||
                         ((key_i[i].vid == vid_i) && (key_i[i].pcp == pcp_i)));
  end

  // lowest index wins
  always_comb begin
    hit_o = |hit_vec;
    idx_o = '0;
    for (int i = N_FLOWS - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = FLOW_W'(i);
    end
  end
endmodule

// File: rtl/psg_gate.sv
module psg_gate
  import psg_pkg::*;
#(
  parameter int TIME_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [TIME_W-1:0] base_i,
  input  logic [TIME_W-1:0] open_ns_i,
  input  logic [TIME_W-1:0] close_ns_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              open_o
);
  gate_st_e          st_q;
  logic              armed_q;
  logic [TIME_W-1:0] edge_q, open_q, close_q;

  // edge-chasing tracker: one window boundary per cycle, no modulo
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= GATE_SHUT;
      armed_q <= 1'b0;
      edge_q  <= '0;
      open_q  <= '0;
      close_q <= '0;
    end else if (restart_i) begin
      st_q    <= GATE_SHUT;
      armed_q <= 1'b1;
      edge_q  <= base_i;
      open_q  <= open_ns_i;
      close_q <= close_ns_i;
    end else if (armed_q && (time_i >= edge_q)) begin
      if (st_q == GATE_SHUT) begin
        st_q   <= GATE_OPEN;
        edge_q <= edge_q + open_q;
      end else begin
        st_q   <= GATE_SHUT;
        edge_q <= edge_q + close_q;
      end
    end
  end

  assign open_o = (st_q == GATE_OPEN);
endmodule

// File: rtl/psg_sat_ctr.sv
module psg_sat_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && (cnt_o != '1)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/psg_policer.sv
module psg_policer
  import psg_pkg::*;
#(
  parameter int N_FLOWS = 8,
  parameter int PORTS   = 5,
  parameter int CNT_W   = 16,
  parameter int TIME_W  = 48,
  parameter int LEN_W   = 14,
  localparam int FLOW_W = (N_FLOWS > 1) ? $clog2(N_FLOWS) : 1,
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              hdr_valid_i,
  input  logic [MacW-1:0]   hdr_dmac_i,
  input  logic [VidW-1:0]   hdr_vid_i,
  input  logic [PcpW-1:0]   hdr_pcp_i,
  input  logic [LEN_W-1:0]  hdr_len_i,
  input  logic [PORT_W-1:0] hdr_port_i,
  input  logic              cfg_we_i,
  input  logic [FLOW_W-1:0] cfg_idx_i,
  input  logic              cfg_vlan_aware_i,
  input  logic [MacW-1:0]   cfg_dmac_i,
  input  logic [VidW-1:0]   cfg_vid_i,
  input  logic [PcpW-1:0]   cfg_pcp_i,
  input  logic [PORTS-1:0]  cfg_ports_i,
  input  logic [LEN_W-1:0]  cfg_max_len_i,
  input  logic [TIME_W-1:0] cfg_base_i,
  input  logic [TIME_W-1:0] cfg_open_i,
  input  logic [TIME_W-1:0] cfg_close_i,
  output logic              dec_valid_o,
  output logic              dec_fwd_o,
  output logic              dec_drop_o,
  output logic              dec_unmatched_o,
  output logic [FLOW_W-1:0] dec_flow_o,
  output logic [PORTS-1:0]  dec_ports_o,
  input  logic [FLOW_W-1:0] cnt_idx_i,
  output logic [CNT_W-1:0]  cnt_acc_o,
  output logic [CNT_W-1:0]  cnt_drop_o
);
  logic [N_FLOWS-1:0]             ent_vld_q;
  flow_key_t [N_FLOWS-1:0]        key_q;
  logic [N_FLOWS-1:0][PORTS-1:0]  ports_q;
  logic [N_FLOWS-1:0][LEN_W-1:0]  max_len_q;

  logic                           cfg_ok;
  logic [N_FLOWS-1:0]             wr_sel, gate_open, acc_inc, drop_inc;
  logic [N_FLOWS-1:0][CNT_W-1:0]  acc_cnt, drop_cnt;
  logic                           hit, pass;
  logic [FLOW_W-1:0]              idx;
  logic [PORTS-1:0]               eff_ports;

  // an entry without a routing action is refused
  assign cfg_ok = cfg_we_i && (|cfg_ports_i) && (int'(cfg_idx_i) < N_FLOWS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_vld_q <= '0;
      key_q     <= '0;
      ports_q   <= '0;
      max_len_q <= '0;
    end else begin
      for (int i = 0; i < N_FLOWS; i++) begin
        if (wr_sel[i]) begin
          ent_vld_q[i] <= 1'b1;
          key_q[i]     <= '{vlan_aware: cfg_vlan_aware_i, dmac: cfg_dmac_i,
                            vid: cfg_vid_i, pcp: cfg_pcp_i};
          ports_q[i]   <= cfg_ports_i;
          max_len_q[i] <= cfg_max_len_i;
        end
      end
    end
  end

  psg_flow_match #(.N_FLOWS(N_FLOWS), .FLOW_W(FLOW_W)) u_match (
    .vld_i  (ent_vld_q),
    .key_i  (key_q),
    .dmac_i (hdr_dmac_i),
    .vid_i  (hdr_vid_i),
    .pcp_i  (hdr_pcp_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  assign eff_ports = ports_q[idx] & ~(PORTS'(1) << hdr_port_i);
  assign pass      = gate_open[idx] && (hdr_len_i <= max_len_q[idx]) && (|eff_ports);

  for (genvar i = 0; i < N_FLOWS; i++) begin : g_flow
    assign wr_sel[i]   = cfg_ok && (cfg_idx_i == FLOW_W'(i));
    assign acc_inc[i]  = hdr_valid_i && hit && (idx == FLOW_W'(i)) && pass;
    assign drop_inc[i] = hdr_valid_i && hit && (idx == FLOW_W'(i)) && !pass;

    psg_gate #(.TIME_W(TIME_W)) u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (wr_sel[i]),
      .base_i     (cfg_base_i),
      .open_ns_i  (cfg_open_i),
      .close_ns_i (cfg_close_i),
      .time_i     (time_i),
      .open_o     (gate_open[i])
    );

    psg_sat_ctr #(.CNT_W(CNT_W)) u_acc (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (wr_sel[i]),
      .inc_i (acc_inc[i]), .cnt_o (acc_cnt[i])
    );

    psg_sat_ctr #(.CNT_W(CNT_W)) u_drop (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (wr_sel[i]),
      .inc_i (drop_inc[i]), .cnt_o (drop_cnt[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o     <= 1'b0;
      dec_fwd_o       <= 1'b0;
      dec_drop_o      <= 1'b0;
      dec_unmatched_o <= 1'b0;
      dec_flow_o      <= '0;
      dec_ports_o     <= '0;
    end else begin
      dec_valid_o <= hdr_valid_i;
      if (hdr_valid_i) begin
        dec_unmatched_o <= !hit;
        dec_fwd_o       <= !hit || pass;
        dec_drop_o      <= hit && !pass;
        dec_flow_o      <= idx;
        dec_ports_o     <= (hit && pass) ? eff_ports : '0;
      end
    end
  end

  assign cnt_acc_o  = acc_cnt[cnt_idx_i];
  assign cnt_drop_o = drop_cnt[cnt_idx_i];
endmodule

// File: rtl/psg_policer_chk.sv
module psg_policer_chk #(
  parameter int N_FLOWS = 8,
  parameter int PORTS   = 5,
  parameter int CNT_W   = 16,
  parameter int PORT_W  = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          hdr_valid_i,
  input logic [PORT_W-1:0]             hdr_port_i,
  input logic                          dec_valid_o,
  input logic                          dec_fwd_o,
  input logic                          dec_drop_o,
  input logic                          dec_unmatched_o,
  input logic [PORTS-1:0]              dec_ports_o,
  input logic [N_FLOWS-1:0]            cnt_clr,
  input logic [N_FLOWS-1:0][CNT_W-1:0] acc_cnt,
  input logic [N_FLOWS-1:0][CNT_W-1:0] drop_cnt
);
  AST_DEC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o == $past(hdr_valid_i)); // R14

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> ($countones({dec_fwd_o, dec_drop_o}) == 1)); // R7

  AST_UNMATCHED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_unmatched_o) |-> (dec_fwd_o && (dec_ports_o == '0))); // R4

  AST_FWD_HAS_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_fwd_o && !dec_unmatched_o) |-> (dec_ports_o != '0)); // R9

  AST_NO_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && dec_fwd_o) |-> (((dec_ports_o >> $past(hdr_port_i)) & PORTS'(1)) == '0)); // R6

  for (genvar i = 0; i < N_FLOWS; i++) begin : g_sat
    AST_ACC_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(acc_cnt[i]) == '1) && !$past(cnt_clr[i])) |-> (acc_cnt[i] == '1)); // R11
    AST_DROP_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(drop_cnt[i]) == '1) && !$past(cnt_clr[i])) |-> (drop_cnt[i] == '1)); // R11
  end
endmodule

bind psg_policer psg_policer_chk #(
  .N_FLOWS (N_FLOWS),
  .PORTS   (PORTS),
  .CNT_W   (CNT_W),
  .PORT_W  (PORT_W)
) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .hdr_valid_i     (hdr_valid_i),
  .hdr_port_i      (hdr_port_i),
  .dec_valid_o     (dec_valid_o),
  .dec_fwd_o       (dec_fwd_o),
  .dec_drop_o      (dec_drop_o),
  .dec_unmatched_o (dec_unmatched_o),
  .dec_ports_o     (dec_ports_o),
  .cnt_clr         (wr_sel),
  .acc_cnt         (acc_cnt),
  .drop_cnt        (drop_cnt)
);

// File: tb/psg_policer_tb_top.sv
`timescale 1ns/1ps
module psg_policer_tb_top;
  localparam int NF = 4, NP = 4, CW = 3, TW = 32, LW = 12;

  localparam logic [47:0] MAC_A = 48'h0200_0000_00AA;
  localparam logic [47:0] MAC_B = 48'h0200_0000_00BB;
  localparam logic [47:0] MAC_D = 48'h0200_0000_00DD;
  localparam logic [47:0] MAC_E = 48'h0200_0000_00EE;
  localparam logic [31:0] FOREVER = 32'hFFFF_FFF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [TW-1:0] time_r = '0;
  logic          hv = 1'b0;
  logic [47:0]   h_dmac = '0;
  logic [11:0]   h_vid = '0;
  logic [2:0]    h_pcp = '0;
  logic [LW-1:0] h_len = '0;
  logic [1:0]    h_port = '0;
  logic          c_we = 1'b0, c_aw = 1'b0;
  logic [1:0]    c_idx = '0;
  logic [47:0]   c_dmac = '0;
  logic [11:0]   c_vid = '0;
  logic [2:0]    c_pcp = '0;
  logic [NP-1:0] c_ports = '0;
  logic [LW-1:0] c_len = '0;
  logic [TW-1:0] c_base = '0, c_open = '0, c_close = '0;
  logic [1:0]    r_idx = '0;

  logic          d_v, d_f, d_d, d_u;
  logic [1:0]    d_flow;
  logic [NP-1:0] d_ports;
  logic [CW-1:0] r_acc, r_drop;

  psg_policer #(.N_FLOWS(NF), .PORTS(NP), .CNT_W(CW), .TIME_W(TW), .LEN_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .time_i(time_r),
    .hdr_valid_i(hv), .hdr_dmac_i(h_dmac), .hdr_vid_i(h_vid), .hdr_pcp_i(h_pcp),
    .hdr_len_i(h_len), .hdr_port_i(h_port),
    .cfg_we_i(c_we), .cfg_idx_i(c_idx), .cfg_vlan_aware_i(c_aw), .cfg_dmac_i(c_dmac),
    .cfg_vid_i(c_vid), .cfg_pcp_i(c_pcp), .cfg_ports_i(c_ports), .cfg_max_len_i(c_len),
    .cfg_base_i(c_base), .cfg_open_i(c_open), .cfg_close_i(c_close),
    .dec_valid_o(d_v), .dec_fwd_o(d_f), .dec_drop_o(d_d), .dec_unmatched_o(d_u),
    .dec_flow_o(d_flow), .dec_ports_o(d_ports),
    .cnt_idx_i(r_idx), .cnt_acc_o(r_acc), .cnt_drop_o(r_drop)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic cfg(input logic [1:0] idx, input logic aw, input logic [47:0] mac,
                     input logic [11:0] vid, input logic [2:0] pcp, input logic [NP-1:0] pm,
                     input logic [LW-1:0] ml, input logic [TW-1:0] b, input logic [TW-1:0] o,
                     input logic [TW-1:0] c);
    @(negedge clk);
    c_we = 1'b1; c_idx = idx; c_aw = aw; c_dmac = mac; c_vid = vid; c_pcp = pcp;
    c_ports = pm; c_len = ml; c_base = b; c_open = o; c_close = c;
    @(negedge clk);
    c_we = 1'b0;
  endtask

  task automatic set_time(input logic [TW-1:0] t);
    @(negedge clk);
    time_r = t;
    repeat (16) @(negedge clk);
  endtask

  // outputs sampled at the negedge after the capturing posedge
  task automatic send(input logic [47:0] mac, input logic [11:0] vid, input logic [2:0] pcp,
                      input logic [LW-1:0] len, input logic [1:0] port);
    @(negedge clk);
    hv = 1'b1; h_dmac = mac; h_vid = vid; h_pcp = pcp; h_len = len; h_port = port;
    @(negedge clk);
    hv = 1'b0;
  endtask

  task automatic rd_cnt(input logic [1:0] idx);
    r_idx = idx;
    #0.1;
  endtask

  typedef struct packed {
    logic [TW-1:0] t;
    logic [47:0]   mac;
    logic [11:0]   vid;
    logic [2:0]    pcp;
    logic [LW-1:0] len;
    logic [1:0]    port;
    logic          fwd;
    logic          unm;
    logic [1:0]    flow;
    logic [NP-1:0] ports;
  } vec_t;

  // F0: aware A/10/3 mask 0110 len<=1500 base 1000 open 600 close 400
  // F1: unaware A mask 1000; F2: unaware B mask 0001 len<=100; F3: unaware D mask 0100
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'd500,  MAC_A, 12'd10, 3'd3, 12'd100,  2'd0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R5 before base, R3 F0 wins
    '{32'd1100, MAC_A, 12'd10, 3'd3, 12'd100,  2'd0, 1'b1, 1'b0, 2'd0, 4'b0110}, // R1 R6
    '{32'd1100, MAC_A, 12'd10, 3'd4, 12'd100,  2'd0, 1'b1, 1'b0, 2'd1, 4'b1000}, // R1 pcp miss, R2
    '{32'd1100, MAC_A, 12'd11, 3'd3, 12'd100,  2'd0, 1'b1, 1'b0, 2'd1, 4'b1000}, // R1 vid miss, R2
    '{32'd1100, MAC_A, 12'd10, 3'd3, 12'd100,  2'd1, 1'b1, 1'b0, 2'd0, 4'b0100}, // R6 ingress bit cleared
    '{32'd1100, MAC_A, 12'd10, 3'd3, 12'd1501, 2'd0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R8 over limit
    '{32'd1100, MAC_A, 12'd10, 3'd3, 12'd1500, 2'd0, 1'b1, 1'b0, 2'd0, 4'b0110}, // R8 at limit
    '{32'd1100, MAC_B, 12'd0,  3'd0, 12'd64,   2'd0, 1'b0, 1'b0, 2'd2, 4'b0000}, // R9 empty mask
    '{32'd1100, MAC_B, 12'd7,  3'd5, 12'd64,   2'd2, 1'b1, 1'b0, 2'd2, 4'b0001}, // R2 R6
    '{32'd1100, MAC_E, 12'd10, 3'd3, 12'd64,   2'd0, 1'b1, 1'b1, 2'd0, 4'b0000}, // R4
    '{32'd1599, MAC_A, 12'd10, 3'd3, 12'd100,  2'd0, 1'b1, 1'b0, 2'd0, 4'b0110}, // R5 last open ns
    '{32'd1600, MAC_A, 12'd10, 3'd3, 12'd100,  2'd0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R5 R7 closes
    '{32'd1999, MAC_A, 12'd10, 3'd3, 12'd100,  2'd0, 1'b0, 1'b0, 2'd0, 4'b0000}, // R5 R7
    '{32'd2000, MAC_A, 12'd10, 3'd3, 12'd100,  2'd0, 1'b1, 1'b0, 2'd0, 4'b0110}, // R5 reopens
    '{32'd5300, MAC_A, 12'd10, 3'd3, 12'd100,  2'd0, 1'b1, 1'b0, 2'd0, 4'b0110}, // R5 multi-period jump
    '{32'd5700, MAC_A, 12'd10, 3'd3, 12'd100,  2'd0, 1'b0, 1'b0, 2'd0, 4'b0000}  // R5 R7
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state, R14
    chk("R14 reset dec_valid", d_v, 0);
    rd_cnt(2'd0);
    chk("R10 reset acc", r_acc, 0);
    chk("R7 reset drop", r_drop, 0);
    rst_n = 1'b1;

    cfg(2'd0, 1'b1, MAC_A, 12'd10, 3'd3, 4'b0110, 12'd1500, 32'd1000, 32'd600, 32'd400);
    cfg(2'd1, 1'b0, MAC_A, 12'd0,  3'd0, 4'b1000, 12'd1500, 32'd0, FOREVER, 32'd1);
    cfg(2'd2, 1'b0, MAC_B, 12'd0,  3'd0, 4'b0001, 12'd100,  32'd0, FOREVER, 32'd1);
    cfg(2'd3, 1'b0, MAC_D, 12'd0,  3'd0, 4'b0100, 12'd1500, 32'd0, FOREVER, 32'd1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].t != time_r) set_time(VECS[i].t);
      send(VECS[i].mac, VECS[i].vid, VECS[i].pcp, VECS[i].len, VECS[i].port);
      chk($sformatf("R14 vec%0d valid", i), d_v, 1);
      chk($sformatf("R6/R7 vec%0d fwd", i), d_f, VECS[i].fwd);
      chk($sformatf("R7 vec%0d drop", i), d_d, !VECS[i].fwd);
      chk($sformatf("R4 vec%0d unmatched", i), d_u, VECS[i].unm);
      chk($sformatf("R6 vec%0d ports", i), d_ports, VECS[i].ports);
      if (!VECS[i].unm) chk($sformatf("R3 vec%0d flow", i), d_flow, VECS[i].flow);
    end

    // R14: no decision without a header
    @(negedge clk);
    chk("R14 idle dec_valid", d_v, 0);

    // counters after the table: R3 R4 R7 R8 R9 R10
    rd_cnt(2'd0); chk("R10 F0 acc", r_acc, 6); chk("R7 F0 drop", r_drop, 5);
    rd_cnt(2'd1); chk("R10 F1 acc", r_acc, 2); chk("R3 F1 drop", r_drop, 0);
    rd_cnt(2'd2); chk("R10 F2 acc", r_acc, 1); chk("R9 F2 drop", r_drop, 1);
    rd_cnt(2'd3); chk("R4 F3 acc", r_acc, 0); chk("R4 F3 drop", r_drop, 0);

    // R11 saturation
    for (int k = 0; k < 9; k++) send(MAC_D, 12'd0, 3'd0, 12'd64, 2'd0);
    rd_cnt(2'd3); chk("R11 F3 acc saturates", r_acc, 7);

    // R12 refused write leaves key, mask and counters
    cfg(2'd3, 1'b0, MAC_E, 12'd0, 3'd0, 4'b0000, 12'd1500, 32'd0, FOREVER, 32'd1);
    send(MAC_E, 12'd0, 3'd0, 12'd64, 2'd0);
    chk("R12 new key unmatched", d_u, 1);
    send(MAC_D, 12'd0, 3'd0, 12'd64, 2'd0);
    chk("R12 old key flow", d_flow, 3);
    chk("R12 old mask", d_ports, 4'b0100);
    rd_cnt(2'd3); chk("R12 counter kept", r_acc, 7);

    // R13 accepted write clears counters
    cfg(2'd3, 1'b0, MAC_D, 12'd0, 3'd0, 4'b0100, 12'd1500, 32'd0, FOREVER, 32'd1);
    rd_cnt(2'd3); chk("R13 acc cleared", r_acc, 0); chk("R13 drop cleared", r_drop, 0);
    repeat (2) @(negedge clk);
    send(MAC_D, 12'd0, 3'd0, 12'd64, 2'd0);
    rd_cnt(2'd3); chk("R13 acc after clear", r_acc, 1);

    // R13 gate restart: F0 rebased to 6000 while time is 5700
    cfg(2'd0, 1'b1, MAC_A, 12'd10, 3'd3, 4'b0110, 12'd1500, 32'd6000, 32'd600, 32'd400);
    repeat (2) @(negedge clk);
    send(MAC_A, 12'd10, 3'd3, 12'd100, 2'd0);
    chk("R13 closed before new base", d_d, 1);
    set_time(32'd6000);
    send(MAC_A, 12'd10, 3'd3, 12'd100, 2'd0);
    chk("R13 open at new base", d_f, 1);
    rd_cnt(2'd0); chk("R13 F0 acc", r_acc, 1); chk("R13 F0 drop", r_drop, 1);

    report();
    $finish;
  end
endmodule